// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block receives asynchronous serial frames on a single input line. The line idles high. Each frame has a low start bit, then 7 or 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The block uses a one-clock tick pulse at 16 times the bit rate. A falling edge starts a frame, and every later bit is sampled at the middle of its bit period.

Received bytes go to a data register. The outcome of each frame is shown by four status flags: data full, parity error, framing error and overrun. Software reads these flags through a small register port. A flag can only be cleared by a handshake: software reads the flag while it is 1, then writes 0 to that bit.

While a parity error or framing error is pending, the receiver ignores the line. No new frame can be lost silently behind an unhandled error.

Top module: `sio_rx_top`

## Requirements
- R1: After reset the data register reads 0 and all four status flags are 0.
- R2: An error-free 8-bit frame loads its byte, least significant bit first, into the data register and sets the full flag (status bit 0).
- R3: With `cfg_seven` high the frame carries 7 data bits, and the data register holds them with bit 7 reading 0.
- R4: With `cfg_par_en` high, a parity bit follows the data. The parity error flag (status bit 1) is set when the number of ones in the data plus the parity bit is odd with `cfg_par_odd` low, or even with `cfg_par_odd` high. The byte is still loaded and the full flag is not set.
- R5: A low first stop bit sets the framing error flag (status bit 2). The byte is still loaded and the full flag is not set.
- R6: With `cfg_two_stop` high, only the first stop bit is checked. A low second stop bit raises no flag.
- R7: While the parity error or framing error flag is 1, no frame is received and no register changes because of line activity.
- R8: Register address 1 is status and address 0 is data. Writing 0 to a status bit clears it only if that bit was read as 1 since the last status write. Any status write discards all earlier reads. Writing 1 has no effect.
- R9: While `rx_en` is low, frames are ignored and the error flags keep their values.
- R10: An error-free frame that ends while the full flag is 1 sets the overrun flag (status bit 3) and leaves the data register unchanged.
- R11: A low pulse on the idle line that has ended by the middle of the start bit (8 ticks after the falling edge) is treated as a false start and ignored.
- R12: A frame with both a parity error and a low first stop bit sets both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x bit rate |
| rx_en | input | 1 | Receive enable |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | Two stop bits per frame |
| cfg_seven | input | 1 | 7 data bits instead of 8 |
| reg_addr | input | 1 | 0 = data register, 1 = status |
| reg_rd | input | 1 | Read strobe, data on `reg_rdata` next cycle |
| reg_wr | input | 1 | Write strobe (status only) |
| reg_wdata | input | 4 | Status write value |
| reg_rdata | output | 8 | Registered read data |
| rx_data | output | 8 | Current data register |
| rx_full | output | 1 | Data full flag |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun flag |

## Verification
The assertions check on every cycle that:
- an error flag never rises together with the full flag;
- the receiver stays idle while an error is pending;
- a flag only falls after a status write of 0 to its bit;
- the error flags hold while reception is disabled;
- the data register holds when overrun rises.

Only the bench scenarios can show the rest: the bit order, the 7-bit packing, the parity arithmetic for both modes, the ignored second stop bit, the rejection of a false start, and the need for a read of 1 before a clearing write.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
    localparam int STAT_W   = 4;
    localparam int FLG_FULL = 0;
    localparam int FLG_PERR = 1;
    localparam int FLG_FERR = 2;
    localparam int FLG_OVR  = 3;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_PAR,
        FS_STOP,
        FS_GUARD
    } frm_state_e;
endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        nxt_d.chain = {cur_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{chain: '1};
        else        cur_q <= nxt_d;
    end

    assign dout = cur_q.chain[STAGES-1];
endmodule

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
    import sio_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    input  logic          rx_en,
    input  logic          lock,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          two_stop,
    input  logic          seven,
    output logic          done,
    output logic [DW-1:0] dout,
    output logic          perr,
    output logic          ferr,
    output logic          busy
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    typedef struct packed {
        frm_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    sh;
        logic             last;
        logic             perr_acc;
        logic             done;
        logic [DW-1:0]    dout;
        logic             perr_o;
        logic             ferr_o;
    } frm_t;

    frm_t cur_q, nxt_d;

    logic [IDX_W-1:0] nbits;
    logic [DW-1:0]    data_now;

    always_comb begin
        nbits    = seven ? IDX_W'(DW - 1) : IDX_W'(DW);
        data_now = seven ? {1'b0, cur_q.sh[DW-1:1]} : cur_q.sh;
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        if (tick) begin
            nxt_d.last = line;
            nxt_d.cnt  = cur_q.cnt + 1'b1;
            unique case (cur_q.st)
                FS_IDLE: begin
                    nxt_d.cnt = '0;
                    if (!lock && cur_q.last && !line) begin
                        nxt_d.st = FS_START;
                    end
                end
                FS_START: begin
                    if (cur_q.cnt == MID) begin
                        nxt_d.cnt = '0;
                        if (!line) begin
                            nxt_d.st       = FS_DATA;
                            nxt_d.idx      = '0;
                            nxt_d.perr_acc = 1'b0;
                        end else begin
                            nxt_d.st = FS_IDLE;
                        end
                    end
                end
                FS_DATA: begin
                    if (cur_q.cnt == LAST) begin
                        nxt_d.cnt = '0;
                        nxt_d.sh  = {line, cur_q.sh[DW-1:1]};
                        nxt_d.idx = cur_q.idx + 1'b1;
                        if (cur_q.idx == nbits - 1'b1) begin
                            nxt_d.st = par_en ? FS_PAR : FS_STOP;
                        end
                    end
                end
                FS_PAR: begin
                    if (cur_q.cnt == LAST) begin
                        nxt_d.cnt      = '0;
                        nxt_d.perr_acc = (^data_now) ^ line ^ par_odd;
                        nxt_d.st       = FS_STOP;
                    end
                end
                FS_STOP: begin
                    if (cur_q.cnt == LAST) begin
                        nxt_d.cnt    = '0;
                        nxt_d.done   = 1'b1;
                        nxt_d.dout   = data_now;
                        nxt_d.ferr_o = !line;
                        nxt_d.perr_o = cur_q.perr_acc;
                        nxt_d.st     = two_stop ? FS_GUARD : FS_IDLE;
                    end
                end
                FS_GUARD: begin
                    if (cur_q.cnt == LAST) begin
                        nxt_d.cnt = '0;
                        nxt_d.st  = FS_IDLE;
                    end
                end
                default: nxt_d.st = FS_IDLE;
            endcase
        end
        if (!rx_en) begin
            nxt_d.st   = FS_IDLE;
            nxt_d.cnt  = '0;
            nxt_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.st   <= FS_IDLE;
            cur_q.last <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign done = cur_q.done;
    assign dout = cur_q.dout;
    assign perr = cur_q.perr_o;
    assign ferr = cur_q.ferr_o;
    assign busy = (cur_q.st != FS_IDLE);
endmodule

// File: rtl/sio_rx_regs.sv
module sio_rx_regs
    import sio_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DW-1:0]     din,
    input  logic              perr,
    input  logic              ferr,
    input  logic              addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     data,
    output logic [STAT_W-1:0] flags
);
    typedef struct packed {
        logic [DW-1:0]     data;
        logic [STAT_W-1:0] flg;
        logic [STAT_W-1:0] arm;
        logic [DW-1:0]     rdata;
    } reg_t;

    reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr && addr) begin
            for (int i = 0; i < STAT_W; i++) begin
                if (cur_q.arm[i] && !wdata[i]) nxt_d.flg[i] = 1'b0;
            end
            nxt_d.arm = '0;
        end
        if (rd) begin
            if (addr) begin
                nxt_d.rdata = {{(DW - STAT_W){1'b0}}, cur_q.flg};
                nxt_d.arm   = nxt_d.arm | cur_q.flg;
            end else begin
                nxt_d.rdata = cur_q.data;
            end
        end
        if (done) begin
            if (perr || ferr) begin
                nxt_d.data = din;
                if (perr) nxt_d.flg[FLG_PERR] = 1'b1;
                if (ferr) nxt_d.flg[FLG_FERR] = 1'b1;
            end else if (nxt_d.flg[FLG_FULL]) begin
                nxt_d.flg[FLG_OVR] = 1'b1;
            end else begin
                nxt_d.data          = din;
                nxt_d.flg[FLG_FULL] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rdata = cur_q.rdata;
    assign data  = cur_q.data;
    assign flags = cur_q.flg;
endmodule

// File: rtl/sio_rx_top.sv
module sio_rx_top
    import sio_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              baud_tick,
    input  logic              rx_en,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_seven,
    input  logic              reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [DW-1:0]     rx_data,
    output logic              rx_full,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun
);
    logic              line_s;
    logic              frm_done;
    logic [DW-1:0]     frm_data;
    logic              frm_perr;
    logic              frm_ferr;
    logic              frm_busy;
    logic [STAT_W-1:0] flags;
    logic              lock;

    assign lock = flags[FLG_PERR] | flags[FLG_FERR];

    sio_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    sio_rx_frame #(.OVS(OVS), .DW(DW)) frame_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .line    (line_s),
        .rx_en   (rx_en),
        .lock    (lock),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .two_stop(cfg_two_stop),
        .seven   (cfg_seven),
        .done    (frm_done),
        .dout    (frm_data),
        .perr    (frm_perr),
        .ferr    (frm_ferr),
        .busy    (frm_busy)
    );

    sio_rx_regs #(.DW(DW)) regs_i (
        .clk  (clk),
        .rst_n(rst_n),
        .done (frm_done),
        .din  (frm_data),
        .perr (frm_perr),
        .ferr (frm_ferr),
        .addr (reg_addr),
        .rd   (reg_rd),
        .wr   (reg_wr),
        .wdata(reg_wdata),
        .rdata(reg_rdata),
        .data (rx_data),
        .flags(flags)
    );

    assign rx_full     = flags[FLG_FULL];
    assign err_parity  = flags[FLG_PERR];
    assign err_frame   = flags[FLG_FERR];
    assign err_overrun = flags[FLG_OVR];
endmodule

// File: rtl/sio_rx_chk.sv
module sio_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          reg_wr,
    input logic          reg_addr,
    input logic [3:0]    reg_wdata,
    input logic          rx_full,
    input logic          err_parity,
    input logic          err_frame,
    input logic          err_overrun,
    input logic [DW-1:0] rx_data,
    input logic          frm_busy
);
    // R4 / R5: an erroneous frame never sets the full flag
    a_r4_err_no_full: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_parity) || $rose(err_frame)) |-> !$rose(rx_full));

    // R7: the receiver stays idle while an error is pending
    a_r7_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_parity || err_frame) && !frm_busy) |=> !frm_busy);

    // R8: an error flag only falls after a status write of 0 to its bit
    a_r8_perr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_parity) |-> $past(reg_wr && reg_addr && !reg_wdata[1]));

    // R8: the full flag only falls after a status write of 0 to bit 0
    a_r8_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(reg_wr && reg_addr && !reg_wdata[0]));

    // R9: the error flags hold while reception is disabled
    a_r9_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !$past(rx_en) && !(reg_wr && reg_addr))
        |=> ($stable(err_frame) && $stable(err_parity)));

    // R10: the data register holds when overrun rises
    a_r10_keep_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $stable(rx_data));
endmodule

bind sio_rx_top sio_rx_chk #(.DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .rx_full    (rx_full),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .err_overrun(err_overrun),
    .rx_data    (rx_data),
    .frm_busy   (frm_busy)
);

// File: tb/sio_rx_top_tb_top.sv
module sio_rx_top_tb_top;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_seven = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_wdata = 4'h0;
    logic [7:0] reg_rdata;
    logic [7:0] rx_data;
    logic       rx_full, err_parity, err_frame, err_overrun;

    int compared = 0;
    int mismatched = 0;
    bit cmp_en = 1'b0;
    bit done_run = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] exp_data = 8'h00;
    logic [3:0] exp_flg = 4'h0;
    logic [3:0] exp_arm = 4'h0;

    always #10 clk = ~clk;

    sio_rx_top dut_i (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
        .rx_en(rx_en), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_seven(cfg_seven),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_data(rx_data),
        .rx_full(rx_full), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun)
    );

    int div = 0;
    always @(posedge clk) begin
        div <= (div == 3) ? 0 : div + 1;
        baud_tick <= (div == 3);
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_en && !done_run) begin
            check(cur_req, {err_overrun, err_frame, err_parity, rx_full, 4'h0},
                  {exp_flg, 4'h0});
            check(cur_req, rx_data, exp_data);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic read_reg(logic a, logic [7:0] exp);
        reg_addr = a; reg_rd = 1'b1;
        cyc(1);
        reg_rd = 1'b0;
        if (a) exp_arm = exp_arm | exp_flg;
        check(cur_req, reg_rdata, exp);
    endtask

    task automatic write_stat(logic [3:0] w);
        reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = w;
        cyc(1);
        reg_wr = 1'b0;
        for (int i = 0; i < 4; i++) if (exp_arm[i] && !w[i]) exp_flg[i] = 1'b0;
        exp_arm = 4'h0;
    endtask

    task automatic clear_all();
        read_reg(1'b1, {4'h0, exp_flg});
        write_stat(4'h0);
    endtask

    function automatic logic good_par(logic [7:0] d, logic odd);
        int ones = 0;
        for (int i = 0; i < 8; i++) if (d[i]) ones++;
        return (ones % 2 == 1) ? !odd : odd;
    endfunction

    // sends one frame and then applies the expected outcome to the model
    task automatic send(logic [7:0] d, logic pbit, logic s1, logic s2);
        int nb = cfg_seven ? 7 : 8;
        logic [7:0] dm = cfg_seven ? {1'b0, d[6:0]} : d;
        logic pe = 1'b0, fe;
        int ones = 0;
        cmp_en = 1'b0;
        rx_line = 1'b0; cyc(BITCLK);
        for (int i = 0; i < nb; i++) begin rx_line = d[i]; cyc(BITCLK); end
        if (cfg_par_en) begin rx_line = pbit; cyc(BITCLK); end
        rx_line = s1; cyc(BITCLK);
        if (cfg_two_stop) begin rx_line = s2; cyc(BITCLK); end
        rx_line = 1'b1; cyc(40);
        for (int i = 0; i < 8; i++) if (dm[i]) ones++;
        if (cfg_par_en) begin
            if (pbit) ones++;
            pe = cfg_par_odd ? (ones % 2 == 0) : (ones % 2 == 1);
        end
        fe = !s1;
        if (rx_en && !exp_flg[1] && !exp_flg[2]) begin
            if (pe || fe) begin
                exp_data = dm;
                if (pe) exp_flg[1] = 1'b1;
                if (fe) exp_flg[2] = 1'b1;
            end else if (exp_flg[0]) begin
                exp_flg[3] = 1'b1;
            end else begin
                exp_data = dm;
                exp_flg[0] = 1'b1;
            end
        end
        cmp_en = 1'b1;
    endtask

    task automatic finish_run();
        done_run = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        // R1: reset state
        cur_req = "R1";
        cmp_en = 1'b1;
        read_reg(1'b1, 8'h00);
        read_reg(1'b0, 8'h00);
        rx_en = 1'b1;
        cyc(20);

        // R2: 8-bit frame, LSB first
        cur_req = "R2";
        send(8'hA5, 1'b0, 1'b1, 1'b1);
        read_reg(1'b0, 8'hA5);

        // R10: second good frame while full -> overrun, data kept
        cur_req = "R10";
        send(8'h3C, 1'b0, 1'b1, 1'b1);
        read_reg(1'b0, 8'hA5);

        // R8: write 0 without a prior read does nothing; read then write clears
        cur_req = "R8";
        write_stat(4'h0);
        cyc(3);
        clear_all();
        cyc(3);

        // R3: 7-bit data
        cur_req = "R3";
        cfg_seven = 1'b1;
        send(8'hD5, 1'b0, 1'b1, 1'b1);
        read_reg(1'b0, 8'h55);
        clear_all();
        cfg_seven = 1'b0;

        // R4: even parity correct, then odd parity wrong
        cur_req = "R4";
        cfg_par_en = 1'b1;
        send(8'h81, good_par(8'h81, 1'b0), 1'b1, 1'b1);
        clear_all();
        cfg_par_odd = 1'b1;
        send(8'h07, good_par(8'h07, 1'b1), 1'b1, 1'b1);
        clear_all();
        send(8'h66, !good_par(8'h66, 1'b1), 1'b1, 1'b1);

        // R7: locked while parity error pending
        cur_req = "R7";
        send(8'h11, good_par(8'h11, 1'b1), 1'b1, 1'b1);

        // R8: write 1 after read does nothing, then write 0 with stale read does nothing
        cur_req = "R8";
        read_reg(1'b1, {4'h0, exp_flg});
        write_stat(4'hF);
        cyc(3);
        write_stat(4'h0);
        cyc(3);
        clear_all();
        cyc(3);
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;

        // R5: framing error
        cur_req = "R5";
        send(8'h5A, 1'b0, 1'b0, 1'b1);
        read_reg(1'b0, 8'h5A);

        // R9: disable with error pending, flags unchanged
        cur_req = "R9";
        rx_en = 1'b0;
        cyc(100);
        clear_all();
        send(8'h77, 1'b0, 1'b1, 1'b1);
        read_reg(1'b1, 8'h00);
        rx_en = 1'b1;
        cyc(20);

        // R6: two stop bits, second low ignored, first low flagged
        cur_req = "R6";
        cfg_two_stop = 1'b1;
        send(8'hC3, 1'b0, 1'b1, 1'b0);
        read_reg(1'b0, 8'hC3);
        clear_all();
        send(8'h24, 1'b0, 1'b0, 1'b1);
        clear_all();
        cfg_two_stop = 1'b0;

        // R12: parity and framing error together
        cur_req = "R12";
        cfg_par_en = 1'b1;
        send(8'h0F, !good_par(8'h0F, 1'b0), 1'b0, 1'b1);
        read_reg(1'b1, 8'h06);
        clear_all();
        cfg_par_en = 1'b0;

        // R11: short low glitch on idle line is ignored, next frame received
        cur_req = "R11";
        rx_line = 1'b0; cyc(12);
        rx_line = 1'b1; cyc(200);
        read_reg(1'b1, 8'h00);
        send(8'h9E, 1'b0, 1'b1, 1'b1);
        read_reg(1'b0, 8'h9E);

        cyc(10);
        finish_run();
    end
endmodule